// File: doc/BRIEF.md
# Ten-to-eight bit character packer

This block sits between a transmit FIFO that holds 10-bit characters and a downstream encoder that takes 8-bit characters. It pulls characters from the FIFO and repacks their bits into a stream of bytes. Each group of four 10-bit characters becomes exactly five bytes. A residual register carries the leftover high bits of one character until they can be merged into the next byte.

The FIFO side uses a read-style interface: data, an empty flag and a read strobe. On the output side there is a byte bus with a valid strobe, a ready input, and a control flag that marks a special character. The FIFO may run dry while some bits of a character are still unsent. In that case the block zero-pads the partial byte and sends it. Directly after that it sends one fill control character, and this restarts packing at the first position of a group.

If the FIFO is empty and no bits are pending, the block emits nothing. While ready is low, every transfer stalls. The block uses a synchronous reset.

Top module: `char_packer`

## Requirements
- R1: After synchronous reset, with the FIFO empty, `out_valid` and `fifo_rd` are both low and no bits are pending.
- R2: For FIFO characters A, B, C, D taken at the start of a group, the first four bytes are A[7:0], {B[5:0],A[9:8]}, {C[3:0],B[9:6]} and {D[1:0],C[9:4]}. In each byte the leftover bits of the earlier character sit in the low positions.
- R3: The fifth byte of a group is D[9:2]. It comes from the residual register alone, and `fifo_rd` stays low for it.
- R4: After the fifth byte the pattern starts again with the next FIFO character as a new A.
- R5: When the FIFO is empty and residual bits are pending (fewer than 8), the block sends a data byte. Its low bits are the pending bits and every other bit is 0.
- R6: The cycle after a padded byte is accepted, the block offers a fill byte with value 8'hBC and `out_ctrl` = 1. Once the fill is accepted, packing restarts at the first position of a group.
- R7: With the FIFO empty and no bits pending, `out_valid` stays low.
- R8: While `out_valid` is high and `out_ready` is low, `fifo_rd` stays low and the packing position and residual bits do not change.
- R9: `fifo_rd` is high only in a cycle where `fifo_empty` is low and a byte built from that character is accepted (`out_valid` and `out_ready` both high).
- R10: `out_ctrl` is 1 only on the fill byte, and every data or padded byte carries `out_ctrl` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| fifo_data | input | 10 | Character at the head of the transmit FIFO |
| fifo_empty | input | 1 | High when the FIFO holds no character |
| fifo_rd | output | 1 | Pops the FIFO head at the clock edge |
| out_data | output | 8 | Byte offered to the encoder |
| out_valid | output | 1 | Byte on `out_data` is offered |
| out_ready | input | 1 | Encoder takes the byte this cycle |
| out_ctrl | output | 1 | Byte is the fill control character |

## Verification
The assertions assume the FIFO shows its head character whenever `fifo_empty` is low. They also assume the FIFO pops only on `fifo_rd`, so `fifo_data` cannot change under a stalled byte unless the FIFO was empty before. The bench models the FIFO as a queue. It drives the head and the empty flag from that queue and pops only on a sampled read, so those assumptions hold. Pushes and ready are varied randomly, including long dry spells, so padding and fill occur at every residual count.

// File: rtl/pk_pkg.sv
package pk_pkg;
  // where the byte offered this cycle comes from
  typedef enum logic [2:0] {
    SRC_IDLE  = 3'd0,
    SRC_FILL  = 3'd1,
    SRC_HOLD  = 3'd2,
    SRC_MERGE = 3'd3,
    SRC_PAD   = 3'd4
  } pk_src_e;

  localparam logic [7:0] FILL_K285 = 8'hBC;
endpackage

// File: rtl/pk_src_sel.sv
module pk_src_sel
  import pk_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int CNT_W  = 5
) (
  input  logic [CNT_W-1:0] cnt,
  input  logic             fill_pend,
  input  logic             fifo_empty,
  output pk_src_e          src
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

  always_comb begin
    if (fill_pend)        src = SRC_FILL;
    else if (cnt >= FULL) src = SRC_HOLD;
    else if (!fifo_empty) src = SRC_MERGE;
    else if (cnt != '0)   src = SRC_PAD;
    else                  src = SRC_IDLE;
  end
endmodule

// File: rtl/pk_hold.sv
module pk_hold
  import pk_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int CHAR_W = 10,
  parameter int RES_W  = 16,
  parameter int CNT_W  = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fire,
  input  pk_src_e          src,
  input  logic [RES_W-1:0] merged_hi,
  output logic [RES_W-1:0] res,
  output logic [CNT_W-1:0] cnt,
  output logic             fill_pend
);
  localparam logic [CNT_W-1:0] STEP = CNT_W'(CHAR_W - BYTE_W);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

  always_ff @(posedge clk) begin
    if (rst) begin
      res       <= '0;
      cnt       <= '0;
      fill_pend <= 1'b0;
    end else if (fire) begin
      unique case (src)
        SRC_FILL: begin
          res       <= '0;
          cnt       <= '0;
          fill_pend <= 1'b0;
        end
        SRC_HOLD: begin
          res <= res >> BYTE_W;
          cnt <= cnt - FULL;
        end
        SRC_MERGE: begin
          res <= merged_hi;
          cnt <= cnt + STEP;
        end
        SRC_PAD: begin
          res       <= '0;
          cnt       <= '0;
          fill_pend <= 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pk_emit.sv
module pk_emit
  import pk_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int RES_W  = 16,
  parameter int CNT_W  = 5,
  parameter logic [BYTE_W-1:0] FILL_CODE = FILL_K285
) (
  input  pk_src_e           src,
  input  logic [RES_W-1:0]  res,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [BYTE_W-1:0] merged_lo,
  output logic [BYTE_W-1:0] data,
  output logic              ctrl,
  output logic              valid
);
  // keep only the pending residual bits, zeros above them
  function automatic logic [BYTE_W-1:0] pad_byte(input logic [RES_W-1:0] r,
                                                 input logic [CNT_W-1:0] n);
    logic [RES_W-1:0] mask;
    mask = (RES_W'(1) << n) - RES_W'(1);
    return BYTE_W'(r & mask);
  endfunction

  always_comb begin
    data  = '0;
    ctrl  = 1'b0;
    valid = 1'b1;
    unique case (src)
      SRC_FILL:  begin data = FILL_CODE; ctrl = 1'b1; end
      SRC_HOLD:  data = res[BYTE_W-1:0];
      SRC_MERGE: data = merged_lo;
      SRC_PAD:   data = pad_byte(res, cnt);
      default:   valid = 1'b0;
    endcase
  end
endmodule

// File: rtl/char_packer.sv
module char_packer
  import pk_pkg::*;
#(
  parameter int CHAR_W = 10,
  parameter int BYTE_W = 8,
  parameter logic [BYTE_W-1:0] FILL_CODE = FILL_K285
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CHAR_W-1:0] fifo_data,
  input  logic              fifo_empty,
  output logic              fifo_rd,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_ctrl
);
  localparam int RES_W  = 2 * BYTE_W;
  localparam int CNT_W  = $clog2(RES_W + 1);
  localparam int COMB_W = CHAR_W + BYTE_W;

  pk_src_e          src;
  logic [RES_W-1:0] res;
  logic [CNT_W-1:0] cnt;
  logic             fill_pend;
  logic [RES_W-1:0] merged_hi;
  logic [BYTE_W-1:0] merged_lo;
  logic             fire;

  // named events for the checks
  logic pad_taken, fill_taken, hold_taken, read_taken;

  // head character shifted above the pending residual bits
  function automatic logic [COMB_W-1:0] merge(input logic [CHAR_W-1:0] ch,
                                              input logic [RES_W-1:0]  r,
                                              input logic [CNT_W-1:0]  n);
    return (COMB_W'(ch) << n) | COMB_W'(r[BYTE_W-1:0]);
  endfunction

  logic [COMB_W-1:0] comb;
  assign comb      = merge(fifo_data, res, cnt);
  assign merged_lo = comb[BYTE_W-1:0];
  assign merged_hi = RES_W'(comb >> BYTE_W);

  pk_src_sel #(.BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_sel (
    .cnt(cnt), .fill_pend(fill_pend), .fifo_empty(fifo_empty), .src(src)
  );

  pk_emit #(.BYTE_W(BYTE_W), .RES_W(RES_W), .CNT_W(CNT_W),
            .FILL_CODE(FILL_CODE)) u_emit (
    .src(src), .res(res), .cnt(cnt), .merged_lo(merged_lo),
    .data(out_data), .ctrl(out_ctrl), .valid(out_valid)
  );

  assign fire = out_valid && out_ready;

  pk_hold #(.BYTE_W(BYTE_W), .CHAR_W(CHAR_W), .RES_W(RES_W),
            .CNT_W(CNT_W)) u_hold (
    .clk(clk), .rst(rst), .fire(fire), .src(src), .merged_hi(merged_hi),
    .res(res), .cnt(cnt), .fill_pend(fill_pend)
  );

  assign read_taken = fire && (src == SRC_MERGE);
  assign pad_taken  = fire && (src == SRC_PAD);
  assign fill_taken = fire && (src == SRC_FILL);
  assign hold_taken = fire && (src == SRC_HOLD);
  assign fifo_rd    = read_taken;

  // R9
  no_empty_read_chk: assert property (@(posedge clk) disable iff (rst)
    fifo_rd |-> (!fifo_empty && out_valid && out_ready));

  // R6
  fill_follows_pad_chk: assert property (@(posedge clk) disable iff (rst)
    pad_taken |=> (out_valid && out_ctrl && out_data == FILL_CODE));

  // R6
  phase_restart_chk: assert property (@(posedge clk) disable iff (rst)
    fill_taken |=> (cnt == '0 && !out_ctrl));

  // R10
  ctrl_only_fill_chk: assert property (@(posedge clk) disable iff (rst)
    out_ctrl |-> (out_data == FILL_CODE && fill_pend));

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> ($stable(cnt) && $stable(res) && $stable(fill_pend)));

  // R3
  hold_no_read_chk: assert property (@(posedge clk) disable iff (rst)
    hold_taken |-> !fifo_rd);

  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (fifo_empty && cnt == '0 && !fill_pend) |-> !out_valid);
endmodule

// File: tb/char_packer_bench.sv
module char_packer_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [9:0] fifo_data = '0;
  logic       fifo_empty = 1'b1;
  logic       fifo_rd;
  logic [7:0] out_data;
  logic       out_valid;
  logic       out_ready = 1'b0;
  logic       out_ctrl;

  always #(CLK_PERIOD/2) clk = ~clk;

  char_packer u_char_packer (
    .clk(clk), .rst(rst), .fifo_data(fifo_data), .fifo_empty(fifo_empty),
    .fifo_rd(fifo_rd), .out_data(out_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_ctrl(out_ctrl)
  );

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [9:0] fq[$];
  logic [8:0] got[$];   // {ctrl, data} of accepted bytes

  // reference state: pending bit count, pending bits, fill owed
  int m_cnt = 0;
  int m_res = 0;
  bit m_fill = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one clock: drive FIFO head, compare, advance reference
  task automatic step();
    bit emp;
    int ch, ed, kind;
    bit ev, ec, erd, acc;
    emp = (fq.size() == 0);
    ch  = emp ? 0 : int'(fq[0]);
    fifo_empty = emp;
    fifo_data  = emp ? 10'd0 : fq[0];
    #1;
    ev = 1; ec = 0; ed = 0;
    if (m_fill)         begin kind = 1; ed = 8'hBC; ec = 1; end
    else if (m_cnt >= 8) begin kind = 2; ed = m_res & 8'hFF; end
    else if (!emp)      begin kind = 3; ed = ((ch << m_cnt) | m_res) & 8'hFF; end
    else if (m_cnt > 0) begin kind = 4; ed = m_res & ((1 << m_cnt) - 1); end
    else                begin kind = 0; ev = 0; end
    acc = ev && out_ready;
    erd = acc && kind == 3;
    chk(out_valid == ev, (kind == 0) ? "R7 valid" : "R1 valid", out_valid, ev);
    chk(fifo_rd == erd, out_ready ? "R9 rd" : "R8 rd", fifo_rd, erd);
    if (ev) begin
      case (kind)
        1: chk({out_ctrl, out_data} == {ec, 8'(ed)}, "R6 fill", {out_ctrl, out_data}, {ec, 8'(ed)});
        2: chk({out_ctrl, out_data} == {ec, 8'(ed)}, "R3 hold", {out_ctrl, out_data}, {ec, 8'(ed)});
        3: chk({out_ctrl, out_data} == {ec, 8'(ed)}, "R2 merge", {out_ctrl, out_data}, {ec, 8'(ed)});
        default: chk({out_ctrl, out_data} == {ec, 8'(ed)}, "R5 pad", {out_ctrl, out_data}, {ec, 8'(ed)});
      endcase
      chk(out_ctrl == (kind == 1), "R10 ctrl", out_ctrl, kind == 1);
    end
    if (acc) got.push_back({out_ctrl, out_data});
    @(posedge clk);
    if (acc) begin
      case (kind)
        1: begin m_fill = 0; m_cnt = 0; m_res = 0; end
        2: begin m_res = m_res >> 8; m_cnt -= 8; end
        3: begin m_res = ((ch << m_cnt) | m_res) >> 8; m_cnt += 2; end
        4: begin m_fill = 1; m_cnt = 0; m_res = 0; end
        default: ;
      endcase
    end
    if (erd) void'(fq.pop_front());
    @(negedge clk);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic got_chk(input int idx, input logic [8:0] exp, input string req);
    logic [8:0] a;
    a = (idx < got.size()) ? got[idx] : 9'h1FF;
    chk(a == exp, req, a, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [9:0] a, b, c, d, e;
    @(negedge clk); @(negedge clk); @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    #1;
    chk(out_valid == 0 && fifo_rd == 0, "R1 reset", {out_valid, fifo_rd}, 0);
    @(negedge clk);
    out_ready = 1'b1;
    run(4);   // R7 idle with empty FIFO

    // R2 R3 R4: two full groups back to back
    a = 10'h2B5; b = 10'h1C3; c = 10'h36A; d = 10'h0F1; e = 10'h3C7;
    got.delete();
    fq.push_back(a); fq.push_back(b); fq.push_back(c); fq.push_back(d);
    fq.push_back(e); fq.push_back(b); fq.push_back(c); fq.push_back(a);
    run(14);
    got_chk(0, {1'b0, a[7:0]}, "R2 byte0");
    got_chk(1, {1'b0, b[5:0], a[9:8]}, "R2 byte1");
    got_chk(2, {1'b0, c[3:0], b[9:6]}, "R2 byte2");
    got_chk(3, {1'b0, d[1:0], c[9:4]}, "R2 byte3");
    got_chk(4, {1'b0, d[9:2]}, "R3 byte4");
    got_chk(5, {1'b0, e[7:0]}, "R4 restart");
    got_chk(9, {1'b0, a[9:2]}, "R4 byte9");
    chk(got.size() == 10, "R7 count", got.size(), 10);

    // R5 R6: underflow after one character
    got.delete();
    fq.push_back(10'h3FF);
    run(5);
    got_chk(0, 9'h0FF, "R5 first");
    got_chk(1, 9'h003, "R5 pad");
    got_chk(2, 9'h1BC, "R6 fill");
    // phase restarts: next character starts a new group
    got.delete();
    fq.push_back(a);
    run(1);
    got_chk(0, {1'b0, a[7:0]}, "R6 restart");
    run(4);

    // R5: underflow after three characters (six pending bits)
    got.delete();
    fq.push_back(a); fq.push_back(b); fq.push_back(c);
    run(7);
    got_chk(3, {1'b0, 2'b00, c[9:4]}, "R5 pad6");
    got_chk(4, 9'h1BC, "R6 fill6");

    // R8: stall with a pending byte
    got.delete();
    fq.push_back(d);
    out_ready = 1'b0;
    run(4);
    chk(got.size() == 0, "R8 stall", got.size(), 0);
    out_ready = 1'b1;
    run(5);
    got_chk(0, {1'b0, d[7:0]}, "R8 resume");

    // random traffic with dry spells
    for (int i = 0; i < 4000; i++) begin
      if ((i / 200) % 2 == 0) begin
        if (fq.size() < 8 && ($urandom % 3) != 0) fq.push_back(10'($urandom));
      end else begin
        if (fq.size() < 8 && ($urandom % 9) == 0) fq.push_back(10'($urandom));
      end
      out_ready = ($urandom % 4) != 0;
      step();
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule